// File: doc/BRIEF.md
# Page Translation Cache with Whole-Cache Flush

This block keeps a small, fully associative set of recently used translations from a linear page number to a physical frame number. It sits in front of a page-table walker. A lookup presents a 32-bit linear address and a write flag. Within the same cycle the block answers either with a hit and the physical address, or with a miss. On a miss the walker resolves the translation and hands its result back through a fill port. The entry is installed on the next clock edge, but only if the walk found the mapping present.

Invalidation is all or nothing. A reload of the page-directory base register clears every entry on the next edge, and so does a task-switch flush pulse. A write lookup that lands on an entry whose recorded dirty flag is clear is reported as a miss. This forces a walk that marks the page dirty in memory. The walker then refills the entry with the dirty flag set. When paging is switched off, lookups return the linear address untouched and the stored translations stay as they are.

Top module: `page_xlate_cache`

## Requirements
- R1: On a hit with paging enabled, `lkPhys` is the stored 20-bit frame in bits 31:12 followed by `lkAddr[11:0]` unchanged; the tag compared is `lkAddr[31:12]`.
- R2: A fill with `fillValid=1` and `fillPresent=1` while paging is enabled and no flush is requested installs the page; from the next cycle, a read lookup of that page hits and returns the filled frame.
- R3: A fill with `fillPresent=0` installs nothing: a later lookup of that page misses and no stored entry is displaced.
- R4: A cycle with `baseWrite=1` invalidates every entry; every lookup in the following cycles misses until new fills arrive.
- R5: A cycle with `taskFlush=1` invalidates every entry in the same way as R4.
- R6: In a cycle where `baseWrite` or `taskFlush` is high, a lookup with paging enabled misses, and a fill offered in that cycle is discarded.
- R7: A write lookup (`lkWrite=1`) of a stored page whose recorded dirty flag is 0 misses, while a read lookup of it hits; once the page is refilled with `fillDirty=1`, write lookups hit.
- R8: There are 8 entries. With all 8 valid, a fill of a new page replaces the least recently used entry, where both hits and fills count as uses. A missing lookup is not a use. Empty entries are used before any replacement.
- R9: A fill of a page that is already stored rewrites that entry in place and never creates a second copy or evicts another entry.
- R10: With `pagingOn=0`, `lkHit` equals `lkValid` and a valid lookup returns `lkPhys = lkAddr`. Fills are ignored, and the stored entries are unchanged when paging returns.
- R11: After reset every entry is invalid, so with paging enabled every lookup misses.
- R12: When `lkHit` is 0, `lkPhys` is 0; `lkHit` is never 1 while `lkValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pagingOn | input | 1 | 1 = translate through the cache, 0 = pass linear address through |
| lkValid | input | 1 | Lookup request this cycle |
| lkAddr | input | 32 | Linear address to translate |
| lkWrite | input | 1 | Lookup is for a write access |
| lkHit | output | 1 | Lookup answered from the cache (or bypassed) |
| lkPhys | output | 32 | Physical address on a hit, 0 otherwise |
| fillValid | input | 1 | Walker result offered this cycle |
| fillVpn | input | 20 | Linear page number the walk resolved |
| fillFrame | input | 20 | Physical frame number from the walk |
| fillDirty | input | 1 | Dirty flag of the page as left by the walk |
| fillPresent | input | 1 | Walk found a present mapping |
| baseWrite | input | 1 | Directory base register reloaded this cycle |
| taskFlush | input | 1 | Task switch changed the directory base |

## Verification
Several corner cases are covered. Replacement order is tracked through a mix of hits and fills, and a design that aged entries on misses, or took the oldest fill instead of the oldest use, would evict a page that is still live and miss on it. A refill of a page that is already stored is followed by lookups of all eight pages, which exposes a design that duplicates the tag and silently evicts a neighbour. The dirty rule is tested by reading, then writing, then refilling the same page; a design that ignored the recorded flag would let a write through without the walker ever marking the page dirty. Flushes are issued together with a lookup and with a fill, where a design that let the old contents answer, or let the fill survive, would return a stale frame after the base changed. Separate tests show that paging-off fills leave the contents unchanged and that faulting walks leave them unchanged.

// File: rtl/xc_pkg.sv
package xc_pkg;

  // Strobes from control to the entry store, all taking effect on the clock edge
  typedef struct packed {
    logic flush;   // clear every valid bit
    logic fill;    // write the entry selected by fillIdx
    logic touch;   // mark the entry selected by touchIdx as most recently used
  } xcStrobe_t;

endpackage

// File: rtl/xc_store.sv
module xc_store
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  xcStrobe_t          strobe,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [VPN_W-1:0]   fillFrame,
  input  logic               fillDirty,
  input  logic [VPN_W-1:0]   lkVpn,
  output logic [ENTRIES-1:0] lkMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic [VPN_W-1:0]   lkFrame,
  output logic               lkDirty
);

  logic [VPN_W-1:0] tagMem   [ENTRIES];
  logic [VPN_W-1:0] frameMem [ENTRIES];
  logic [ENTRIES-1:0] dirtyVec;

  // Valid bits: reset and flush clear all, fill sets one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.flush) begin
      validVec <= '0;
    end else if (strobe.fill) begin
      validVec[fillIdx] <= 1'b1;
    end
  end

  // Payload storage is written only on fill; contents of invalid slots are don't-care
  always_ff @(posedge clk) begin
    if (strobe.fill && !strobe.flush) begin
      tagMem[fillIdx]   <= fillVpn;
      frameMem[fillIdx] <= fillFrame;
      dirtyVec[fillIdx] <= fillDirty;
    end
  end

  // One comparator pair per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lkMatch[e]   = validVec[e] && (tagMem[e] == lkVpn);
    assign fillMatch[e] = validVec[e] && (tagMem[e] == fillVpn);
  end

  // At most one entry matches (fills rewrite in place), so an OR mux suffices
  always_comb begin
    lkFrame = '0;
    lkDirty = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lkMatch[e]) begin
        lkFrame = lkFrame | frameMem[e];
        lkDirty = lkDirty | dirtyVec[e];
      end
    end
  end

endmodule

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int AGE_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pagingOn,
  input  logic               lkValid,
  input  logic               lkWrite,
  input  logic [ENTRIES-1:0] lkMatch,
  input  logic               lkDirty,
  input  logic               fillValid,
  input  logic               fillPresent,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               baseWrite,
  input  logic               taskFlush,
  output xcStrobe_t          strobe,
  output logic [IDX_W-1:0]   fillIdx,
  output logic               hitPaged
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  // Age per entry: 0 = most recent, ENTRIES-1 = least recent; always a permutation
  logic [AGE_W-1:0] age [ENTRIES];

  logic             flushNow;
  logic             fillOk;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] reuseIdx;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;
  logic             anyFree;
  logic [IDX_W-1:0] touchIdx;

  assign flushNow = baseWrite | taskFlush;

  // A write to a clean page must go to the walker so the page gets marked dirty
  assign hitPaged = pagingOn && !flushNow && lkValid && (|lkMatch) &&
                    !(lkWrite && !lkDirty);

  assign fillOk = pagingOn && !flushNow && fillValid && fillPresent;

  // Encoders: lowest index wins
  always_comb begin
    hitIdx   = '0;
    reuseIdx = '0;
    freeIdx  = '0;
    oldIdx   = '0;
    anyFree  = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (lkMatch[e])    hitIdx   = IDX_W'(e);
      if (fillMatch[e])  reuseIdx = IDX_W'(e);
      if (!validVec[e]) begin
        freeIdx = IDX_W'(e);
        anyFree = 1'b1;
      end
      if (age[e] == OLDEST) oldIdx = IDX_W'(e);
    end
  end

  // Fill target: same page in place, else an empty slot, else the oldest entry
  always_comb begin
    if (|fillMatch)   fillIdx = reuseIdx;
    else if (anyFree) fillIdx = freeIdx;
    else              fillIdx = oldIdx;
  end

  // A fill claims the recency update when both happen in one cycle
  assign touchIdx = fillOk ? fillIdx : hitIdx;

  always_comb begin
    strobe.flush = flushNow;
    strobe.fill  = fillOk;
    strobe.touch = fillOk | hitPaged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) age[e] <= AGE_W'(e);
    end else if (strobe.touch) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IDX_W'(e) == touchIdx)       age[e] <= '0;
        else if (age[e] < age[touchIdx]) age[e] <= age[e] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = VPN_W + OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pagingOn,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPhys,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [VPN_W-1:0]  fillFrame,
  input  logic              fillDirty,
  input  logic              fillPresent,
  input  logic              baseWrite,
  input  logic              taskFlush
);

  xcStrobe_t          strobe;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] validVec;
  logic [VPN_W-1:0]   lkFrame;
  logic               lkDirty;
  logic               hitPaged;

  xc_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fillIdx   (fillIdx),
    .fillVpn   (fillVpn),
    .fillFrame (fillFrame),
    .fillDirty (fillDirty),
    .lkVpn     (lkAddr[ADDR_W-1:OFS_W]),
    .lkMatch   (lkMatch),
    .fillMatch (fillMatch),
    .validVec  (validVec),
    .lkFrame   (lkFrame),
    .lkDirty   (lkDirty)
  );

  xc_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pagingOn    (pagingOn),
    .lkValid     (lkValid),
    .lkWrite     (lkWrite),
    .lkMatch     (lkMatch),
    .lkDirty     (lkDirty),
    .fillValid   (fillValid),
    .fillPresent (fillPresent),
    .fillMatch   (fillMatch),
    .validVec    (validVec),
    .baseWrite   (baseWrite),
    .taskFlush   (taskFlush),
    .strobe      (strobe),
    .fillIdx     (fillIdx),
    .hitPaged    (hitPaged)
  );

  assign lkHit  = pagingOn ? hitPaged : lkValid;
  assign lkPhys = !lkHit   ? '0 :
                  pagingOn ? {lkFrame, lkAddr[OFS_W-1:0]} : lkAddr;

endmodule

// File: rtl/page_xlate_cache_chk.sv
module page_xlate_cache_chk #(
  parameter int VPN_W  = 20,
  parameter int OFS_W  = 12,
  localparam int ADDR_W = VPN_W + OFS_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              pagingOn,
  input logic              lkValid,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkWrite,
  input logic              lkHit,
  input logic [ADDR_W-1:0] lkPhys,
  input logic              fillValid,
  input logic [VPN_W-1:0]  fillVpn,
  input logic [VPN_W-1:0]  fillFrame,
  input logic              fillDirty,
  input logic              fillPresent,
  input logic              baseWrite,
  input logic              taskFlush
);

  p_offset_r1: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkPhys[OFS_W-1:0] == lkAddr[OFS_W-1:0]);

  p_fill_then_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pagingOn && fillValid && fillPresent && fillDirty && !baseWrite && !taskFlush)
    |=> (!(pagingOn && lkValid && lkAddr[ADDR_W-1:OFS_W] == $past(fillVpn)) ||
         (lkHit && lkPhys[ADDR_W-1:OFS_W] == $past(fillFrame))));

  p_base_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    baseWrite |=> (!pagingOn || !lkHit));

  p_task_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    taskFlush |=> (!pagingOn || !lkHit));

  p_flush_same_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pagingOn && (baseWrite || taskFlush)) |-> !lkHit);

  p_clean_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pagingOn && fillValid && fillPresent && !fillDirty && !baseWrite && !taskFlush)
    |=> (!(pagingOn && lkValid && lkWrite && lkAddr[ADDR_W-1:OFS_W] == $past(fillVpn))
         || !lkHit));

  p_bypass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!pagingOn && lkValid) |-> (lkHit && lkPhys == lkAddr));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && lkPhys == '0));

  p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> lkPhys == '0);

endmodule

bind page_xlate_cache page_xlate_cache_chk #(.VPN_W(VPN_W), .OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pagingOn    (pagingOn),
  .lkValid     (lkValid),
  .lkAddr      (lkAddr),
  .lkWrite     (lkWrite),
  .lkHit       (lkHit),
  .lkPhys      (lkPhys),
  .fillValid   (fillValid),
  .fillVpn     (fillVpn),
  .fillFrame   (fillFrame),
  .fillDirty   (fillDirty),
  .fillPresent (fillPresent),
  .baseWrite   (baseWrite),
  .taskFlush   (taskFlush)
);

// File: tb/page_xlate_cache_tb.sv
module page_xlate_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pagingOn = 1'b1;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkWrite = 1'b0;
  logic        lkHit;
  logic [31:0] lkPhys;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillFrame = '0;
  logic        fillDirty = 1'b0;
  logic        fillPresent = 1'b0;
  logic        baseWrite = 1'b0;
  logic        taskFlush = 1'b0;

  int total = 0;
  int bad = 0;
  logic        obsHit;
  logic [31:0] obsPhys;

  always #5 clk = ~clk;

  page_xlate_cache u_dut (
    .clk(clk), .rstN(rstN), .pagingOn(pagingOn),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite),
    .lkHit(lkHit), .lkPhys(lkPhys),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillFrame(fillFrame),
    .fillDirty(fillDirty), .fillPresent(fillPresent),
    .baseWrite(baseWrite), .taskFlush(taskFlush)
  );

  function automatic logic [19:0] fr(input logic [19:0] v);
    return 20'(v * 20'd7 + 20'h3C1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; samples 1 ns later, returns after the next falling edge
  task automatic step(input logic lv, input logic [31:0] a, input logic w,
                      input logic fv, input logic [19:0] fvpn, input logic [19:0] ffr,
                      input logic fd, input logic fp, input logic bw, input logic tf);
    lkValid = lv; lkAddr = a; lkWrite = w;
    fillValid = fv; fillVpn = fvpn; fillFrame = ffr; fillDirty = fd; fillPresent = fp;
    baseWrite = bw; taskFlush = tf;
    #1;
    obsHit = lkHit;
    obsPhys = lkPhys;
    @(posedge clk);
    @(negedge clk);
    lkValid = 0; lkWrite = 0; fillValid = 0; baseWrite = 0; taskFlush = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] f, input logic d, input logic p);
    step(0, '0, 0, 1, v, f, d, p, 0, 0);
  endtask

  task automatic expHit(input string req, input logic [19:0] v, input logic [11:0] ofs,
                        input logic w, input logic [19:0] f);
    step(1, {v, ofs}, w, 0, '0, '0, 0, 0, 0, 0);
    chk(req, {31'd0, obsHit}, 32'd1);
    chk(req, obsPhys, {f, ofs});
  endtask

  task automatic expMiss(input string req, input logic [19:0] v, input logic w);
    step(1, {v, 12'h5A5}, w, 0, '0, '0, 0, 0, 0, 0);
    chk(req, {31'd0, obsHit}, 32'd0);
    chk(req, obsPhys, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11: empty after reset
    for (int v = 0; v < 16; v++) expMiss("R11 reset empty", 20'(v), 0);
    // R12: no request, no hit
    step(0, 32'h0000_1234, 0, 0, '0, '0, 0, 0, 0, 0);
    chk("R12 idle no hit", {31'd0, obsHit}, 32'd0);

    // R10: bypass when paging is off
    pagingOn = 0;
    step(1, 32'hDEAD_BEEF, 0, 0, '0, '0, 0, 0, 0, 0);
    chk("R10 bypass hit", {31'd0, obsHit}, 32'd1);
    chk("R10 bypass addr", obsPhys, 32'hDEAD_BEEF);
    step(0, 32'hDEAD_BEEF, 0, 0, '0, '0, 0, 0, 0, 0);
    chk("R12 bypass idle", {31'd0, obsHit}, 32'd0);
    pagingOn = 1;

    // R2, R1: fill eight pages, then look each up with a varying offset
    for (int i = 0; i < 8; i++) fill(20'(10 + i), fr(20'(10 + i)), 1, 1);
    for (int i = 0; i < 8; i++) expHit("R2 R1 fill then hit", 20'(10 + i), 12'(i * 12'h111), 0, fr(20'(10 + i)));

    // R8: LRU replacement driven by hits and fills
    expHit("R8 touch", 20'd10, 12'hFFF, 0, fr(20'd10));
    fill(20'd30, fr(20'd30), 1, 1);
    expMiss("R8 lru evicted", 20'd11, 0);
    expHit("R8 recent kept", 20'd10, 12'h001, 0, fr(20'd10));
    expHit("R8 new page", 20'd30, 12'h800, 0, fr(20'd30));
    fill(20'd31, fr(20'd31), 1, 1);
    expMiss("R8 second eviction", 20'd12, 0);
    expHit("R8 survivor", 20'd13, 12'h123, 0, fr(20'd13));

    // R9: in-place refill, nothing else displaced
    fill(20'd13, fr(20'd13) ^ 20'hFFFFF, 1, 1);
    expHit("R9 rewritten frame", 20'd13, 12'h0AB, 0, fr(20'd13) ^ 20'hFFFFF);
    expHit("R9 no eviction", 20'd10, 12'h010, 0, fr(20'd10));
    for (int v = 14; v < 18; v++) expHit("R9 no eviction", 20'(v), 12'h020, 0, fr(20'(v)));
    expHit("R9 no eviction", 20'd30, 12'h030, 0, fr(20'd30));
    expHit("R9 no eviction", 20'd31, 12'h040, 0, fr(20'd31));

    // R3: faulting walk is not cached
    fill(20'd40, fr(20'd40), 1, 0);
    expMiss("R3 absent not stored", 20'd40, 0);
    expHit("R3 nothing displaced", 20'd14, 12'h777, 0, fr(20'd14));

    // R7: clean page: read hits, write misses, refill dirty then write hits
    fill(20'd50, fr(20'd50), 0, 1);
    expHit("R7 clean read hits", 20'd50, 12'h321, 0, fr(20'd50));
    expMiss("R7 clean write misses", 20'd50, 1);
    fill(20'd50, fr(20'd50), 1, 1);
    expHit("R7 dirty write hits", 20'd50, 12'h654, 1, fr(20'd50));

    // R10: fill ignored while paging is off, contents kept
    pagingOn = 0;
    fill(20'd60, fr(20'd60), 1, 1);
    pagingOn = 1;
    expMiss("R10 fill ignored", 20'd60, 0);
    expHit("R10 contents kept", 20'd50, 12'h111, 0, fr(20'd50));

    // R6: lookup in flush cycle misses; R4: contents gone afterwards
    step(1, {20'd50, 12'h222}, 0, 0, '0, '0, 0, 0, 1, 0);
    chk("R6 same cycle miss", {31'd0, obsHit}, 32'd0);
    expMiss("R4 base reload flushes", 20'd50, 0);
    expMiss("R4 base reload flushes", 20'd31, 0);
    // R6: fill offered in a flush cycle is dropped
    step(0, '0, 0, 1, 20'd70, fr(20'd70), 1, 1, 0, 1);
    expMiss("R6 fill during flush dropped", 20'd70, 0);

    // R5: task-switch flush
    fill(20'd71, fr(20'd71), 1, 1);
    expHit("R5 before flush", 20'd71, 12'h999, 0, fr(20'd71));
    step(0, '0, 0, 0, '0, '0, 0, 0, 0, 1);
    expMiss("R5 task flush clears", 20'd71, 0);

    // R4: full sweep
    for (int i = 0; i < 8; i++) fill(20'(80 + i), fr(20'(80 + i)), 1, 1);
    expHit("R4 full before reload", 20'd87, 12'h0F0, 0, fr(20'd87));
    step(0, '0, 0, 0, '0, '0, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) expMiss("R4 full sweep cleared", 20'(80 + i), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule